// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous NRZ frames on a single output line. Software writes a character into a holding register. The character moves into a separate shift register as soon as the shifter is idle and transmission is enabled. One character can therefore shift out while the next one waits in the holding register.

Each frame has a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. Bit timing comes from an external one-cycle tick, and each bit lasts 16 ticks. A send-break input replaces ordinary frames with frames that are low for their whole length. When break is released, the line is marked high for one bit time before any queued character goes out. Status outputs report an empty holding register, a completed transmission, and a write that landed on a full holding register.

Top module: `nrz_tx`

## Requirements
- R1: After reset the line `txd_o` is high, `empty_o`=1, `done_o`=1 and `ovr_o`=0. The line stays high whenever no frame, break or mark bit is in progress.
- R2: A frame is one start bit at 0, then the data bits least significant first, then one stop bit at 1. Each bit lasts exactly 16 rising edges on which `tick_i` is 1. The frame begins on the clock edge after the character is loaded into the shifter.
- R3: When `long_i`=1 at load time, the frame carries 9 data bits, and the ninth bit is the value of `ninth_i` latched at load. When `long_i`=0 it carries 8 data bits.
- R4: A write sets the holding register full, so `empty_o` goes to 0 on that edge. The transfer into the shifter sets `empty_o` back to 1. A character written while another shifts out is sent right after it, with at most one idle clock between the two frames.
- R5: `done_o` clears on a write or on the start of a break. It sets at the end of a stop bit, or of a post-break mark bit, when the holding register is empty.
- R6: A write while the holding register is full and not being transferred in that cycle replaces the waiting character and sets `ovr_o`. A write into an empty holding register clears `ovr_o`.
- R7: While `en_i`=0 no new frame starts and a written character waits. Clearing `en_i` during a frame lets that frame finish unchanged.
- R8: While `brk_i`=1 and `en_i`=1, frames of full length that are all 0 (start, data and stop) are sent back to back, ahead of any queued character. After release, the line is high for at least 16 ticks before the queued character starts.
- R9: On edges where `tick_i`=0, the frame does not advance and `txd_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | One-cycle write strobe for the holding register |
| wr_data_i | input | DATA_W | Character to write |
| ninth_i | input | 1 | Ninth data bit, latched when the character is loaded |
| long_i | input | 1 | 1 selects 9 data bits, 0 selects 8, sampled at load |
| en_i | input | 1 | Transmit enable |
| brk_i | input | 1 | Send break while high |
| tick_i | input | 1 | Bit-rate tick, 16 per bit |
| txd_o | output | 1 | Serial output line |
| empty_o | output | 1 | Holding register empty |
| done_o | output | 1 | Transmission complete |
| ovr_o | output | 1 | A write overwrote a waiting character |

## Verification
A write is registered on its edge, and the load into the shifter follows on the next edge. The start bit therefore appears one clock after the write, and `empty_o` drops for exactly that one cycle. With the tick held high, every bit then spans 16 clocks. The bench detects the falling edge of the start bit, waits 7 more falling clock edges to reach mid-bit, and from there samples every 16 clocks. This keeps every sample at least 7 cycles away from a bit boundary. Flag checks are made on falling edges, at a known number of cycles after the write, or about 12 cycles after the mid-stop sample, which is past the frame end at which `done_o` is due.

// File: rtl/nrz_tx_pkg.sv
package nrz_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_BRK,
    ST_MARK
  } tx_st_e;
endpackage

// File: rtl/nrz_tx_bitclk.sv
module nrz_tx_bitclk #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_end_o = tick_i && !clear_i && (cnt_q == LAST);

  p_bit_end_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o && !clear_i |=> !bit_end_o);
endmodule

// File: rtl/nrz_tx_hold.sv
module nrz_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          load_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (wr_i) begin
        data_o <= wr_data_i;
        full_o <= 1'b1;
        // a write racing the transfer is not an overrun
        ovr_o  <= full_o && !load_i;
      end else if (load_i) begin
        full_o <= 1'b0;
      end
    end
  end

  p_ovr_on_full_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && full_o && !load_i |=> ovr_o);
  p_write_fills_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);
  p_load_drains_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !wr_i |=> !full_o);
  p_load_needs_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> full_o);
endmodule

// File: rtl/nrz_tx_shift.sv
module nrz_tx_shift
  import nrz_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_data_i,
  input  logic          go_brk_i,
  input  logic [DW-1:0] char_i,
  input  logic          ninth_i,
  input  logic          long_i,
  input  logic          brk_i,
  input  logic          en_i,
  input  logic          tick_i,
  output logic          txd_o,
  output logic          busy_o,
  output logic          frame_end_o
);
  localparam int FW = DW + 3;
  localparam int BW = $clog2(FW + 1);
  localparam logic [BW-1:0] LAST_SHORT = BW'(DW + 1);
  localparam logic [BW-1:0] LAST_LONG  = BW'(DW + 2);

  tx_st_e         st_q;
  logic [FW-1:0]  sh_q;
  logic [BW-1:0]  idx_q;
  logic [BW-1:0]  last_q;
  logic           bit_end;
  logic           last_bit;
  logic           fill;
  logic           brk_again;

  nrz_tx_bitclk #(.OVS(OVS)) u_bitclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (go_data_i || go_brk_i),
    .tick_i   (tick_i),
    .bit_end_o(bit_end)
  );

  assign last_bit  = (idx_q == last_q);
  assign fill      = (st_q == ST_DATA);
  assign brk_again = brk_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh_q   <= '1;
      idx_q  <= '0;
      last_q <= LAST_SHORT;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (go_data_i) begin
            sh_q   <= {1'b1, (long_i ? ninth_i : 1'b1), char_i, 1'b0};
            last_q <= long_i ? LAST_LONG : LAST_SHORT;
            idx_q  <= '0;
            st_q   <= ST_DATA;
          end else if (go_brk_i) begin
            sh_q   <= '0;
            last_q <= long_i ? LAST_LONG : LAST_SHORT;
            idx_q  <= '0;
            st_q   <= ST_BRK;
          end
        end
        ST_DATA, ST_BRK: begin
          if (bit_end) begin
            if (!last_bit) begin
              sh_q  <= {fill, sh_q[FW-1:1]};
              idx_q <= idx_q + 1'b1;
            end else if (st_q == ST_DATA) begin
              sh_q <= '1;
              st_q <= ST_IDLE;
            end else if (brk_again) begin
              // back-to-back break frames, no high gap
              sh_q   <= '0;
              last_q <= long_i ? LAST_LONG : LAST_SHORT;
              idx_q  <= '0;
            end else begin
              sh_q <= '1;
              st_q <= ST_MARK;
            end
          end
        end
        ST_MARK: begin
          if (bit_end) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_DATA, ST_BRK: txd_o = sh_q[0];
      default:         txd_o = 1'b1;
    endcase
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign frame_end_o = bit_end && (((st_q == ST_DATA) && last_bit) || (st_q == ST_MARK));

  p_no_tick_no_move_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !go_data_i && !go_brk_i |=> $stable(txd_o));
  p_start_bit_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_data_i |=> !txd_o);
  p_go_only_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_data_i || go_brk_i |-> !busy_o);
  p_stop_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> txd_o);
endmodule

// File: rtl/nrz_tx.sv
module nrz_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ninth_i,
  input  logic              long_i,
  input  logic              en_i,
  input  logic              brk_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              done_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              busy;
  logic              frame_end;
  logic              go_data;
  logic              go_brk;

  // break takes priority over a queued character
  assign go_brk  = !busy && en_i && brk_i;
  assign go_data = !busy && en_i && !brk_i && hold_full;

  nrz_tx_hold #(.DW(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .wr_data_i(wr_data_i),
    .load_i   (go_data),
    .data_o   (hold_data),
    .full_o   (hold_full),
    .ovr_o    (ovr_o)
  );

  nrz_tx_shift #(.DW(DATA_W), .OVS(OVS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_data_i  (go_data),
    .go_brk_i   (go_brk),
    .char_i     (hold_data),
    .ninth_i    (ninth_i),
    .long_i     (long_i),
    .brk_i      (brk_i),
    .en_i       (en_i),
    .tick_i     (tick_i),
    .txd_o      (txd_o),
    .busy_o     (busy),
    .frame_end_o(frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b1;
    end else if (wr_i || go_brk) begin
      done_o <= 1'b0;
    end else if (frame_end && !hold_full) begin
      done_o <= 1'b1;
    end
  end

  assign empty_o = !hold_full;

  p_done_line_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> txd_o);
  p_done_needs_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> empty_o);
  p_disabled_stays_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !busy |=> !busy);
  p_write_clears_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !done_o);
endmodule

// File: tb/nrz_tx_tb.sv
module nrz_tx_tb;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       ninth_i = 1'b0;
  logic       long_i = 1'b0;
  logic       en_i = 1'b0;
  logic       brk_i = 1'b0;
  logic       tick_en = 1'b1;
  logic       txd_o, empty_o, done_o, ovr_o;

  int errors = 0;
  int checks = 0;
  bit reported = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  nrz_tx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .ninth_i(ninth_i), .long_i(long_i), .en_i(en_i), .brk_i(brk_i),
    .tick_i(tick_en), .txd_o(txd_o), .empty_o(empty_o), .done_o(done_o),
    .ovr_o(ovr_o)
  );

  // {long, ninth, data}
  localparam logic [9:0] VECS [6] = '{10'h055, 10'h0A3, 10'h001,
                                      10'h380, 10'h2FE, 10'h37F};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic write_char(input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rx_char(input bit nine, output logic [8:0] d, output logic stop_v);
    bit seen = 0;
    d = '0;
    stop_v = 1'b0;
    for (int k = 0; k < 4000 && !seen; k++) begin
      @(negedge clk_i);
      if (!txd_o) seen = 1;
    end
    check(seen, "R2 start bit seen", 0, 1);
    repeat (7) @(negedge clk_i);
    for (int b = 0; b < (nine ? 9 : 8); b++) begin
      repeat (16) @(negedge clk_i);
      d[b] = txd_o;
    end
    repeat (16) @(negedge clk_i);
    stop_v = txd_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    logic [8:0] got;
    logic       stop_v;
    int         highs;
    bit         steady;

    repeat (3) @(negedge clk_i);
    check(txd_o === 1'b1, "R1 reset txd", txd_o, 1);
    check(empty_o === 1'b1, "R1 reset empty", empty_o, 1);
    check(done_o === 1'b1, "R1 reset done", done_o, 1);
    check(ovr_o === 1'b0, "R1 reset ovr", ovr_o, 0);
    rst_ni = 1'b1;
    en_i = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 R3 table walk
    for (int i = 0; i < 6; i++) begin
      long_i  = VECS[i][9];
      ninth_i = VECS[i][8];
      write_char(VECS[i][7:0]);
      rx_char(VECS[i][9], got, stop_v);
      if (VECS[i][9])
        check(got === VECS[i][8:0], "R3 nine-bit data", got, VECS[i][8:0]);
      else
        check(got[7:0] === VECS[i][7:0], "R2 eight-bit data", got[7:0], VECS[i][7:0]);
      check(stop_v === 1'b1, "R2 stop bit", stop_v, 1);
      repeat (12) @(negedge clk_i);
      check(done_o === 1'b1, "R5 done after frame", done_o, 1);
      check(empty_o === 1'b1, "R4 empty after frame", empty_o, 1);
    end
    long_i = 1'b0;
    ninth_i = 1'b0;

    // R4 double buffering
    write_char(8'h3C);
    repeat (2) @(negedge clk_i);
    check(empty_o === 1'b1, "R4 empty after transfer", empty_o, 1);
    write_char(8'hC5);
    check(empty_o === 1'b0, "R4 holding full", empty_o, 0);
    check(done_o === 1'b0, "R5 done cleared by write", done_o, 0);
    rx_char(1'b0, got, stop_v);
    check(got[7:0] === 8'h3C, "R4 first char", got[7:0], 8'h3C);
    rx_char(1'b0, got, stop_v);
    check(got[7:0] === 8'hC5, "R4 second char", got[7:0], 8'hC5);
    check(stop_v === 1'b1, "R2 second stop", stop_v, 1);
    repeat (12) @(negedge clk_i);
    check(done_o === 1'b1, "R5 done after both", done_o, 1);

    // R7 disabled, R6 overrun
    en_i = 1'b0;
    write_char(8'h11);
    steady = 1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_i);
      if (txd_o !== 1'b1) steady = 0;
    end
    check(steady, "R7 no frame while disabled", steady, 1);
    check(empty_o === 1'b0, "R7 char waits", empty_o, 0);
    write_char(8'h96);
    check(ovr_o === 1'b1, "R6 overrun set", ovr_o, 1);
    en_i = 1'b1;
    rx_char(1'b0, got, stop_v);
    check(got[7:0] === 8'h96, "R6 overwritten char sent", got[7:0], 8'h96);
    repeat (12) @(negedge clk_i);
    write_char(8'h5A);
    check(ovr_o === 1'b0, "R6 overrun cleared", ovr_o, 0);

    // R7 enable dropped mid-frame
    fork
      rx_char(1'b0, got, stop_v);
      begin
        repeat (60) @(negedge clk_i);
        en_i = 1'b0;
      end
    join
    check(got[7:0] === 8'h5A, "R7 frame finishes", got[7:0], 8'h5A);
    check(stop_v === 1'b1, "R7 stop after disable", stop_v, 1);
    en_i = 1'b1;
    repeat (12) @(negedge clk_i);

    // R9 no ticks
    tick_en = 1'b0;
    write_char(8'hE7);
    steady = 1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk_i);
      if (txd_o !== 1'b0) steady = 0;
    end
    check(steady, "R9 line frozen without tick", steady, 1);
    tick_en = 1'b1;
    rx_char(1'b0, got, stop_v);
    check(got[7:0] === 8'hE7, "R9 char after resume", got[7:0], 8'hE7);
    repeat (12) @(negedge clk_i);

    // R8 break
    @(negedge clk_i);
    brk_i = 1'b1;
    write_char(8'hA5);
    check(done_o === 1'b0, "R5 done cleared by break", done_o, 0);
    highs = 0;
    for (int k = 0; k < 320; k++) begin
      @(negedge clk_i);
      if (txd_o !== 1'b0) highs++;
    end
    check(highs == 0, "R8 line low during break", highs, 0);
    check(empty_o === 1'b0, "R8 char held behind break", empty_o, 0);
    brk_i = 1'b0;
    steady = 0;
    for (int k = 0; k < 400 && !steady; k++) begin
      @(negedge clk_i);
      if (txd_o === 1'b1) steady = 1;
    end
    highs = 0;
    for (int k = 0; k < 400 && txd_o === 1'b1; k++) begin
      highs++;
      @(negedge clk_i);
    end
    check(highs >= 16, "R8 mark after break", highs, 16);
    rx_char(1'b0, got, stop_v);
    check(got[7:0] === 8'hA5, "R8 queued char after break", got[7:0], 8'hA5);
    repeat (12) @(negedge clk_i);
    check(done_o === 1'b1 && txd_o === 1'b1, "R1 idle high at end", {done_o, txd_o}, 3);

    report();
  end
endmodule